// File: doc/BRIEF.md
# Byte-Count Transfer Sequencer

This block runs the master side of a serial transfer one byte at a time. A host programs a control word and a byte count. When a start is accepted the block asks an external bus engine for an address phase toward the target address. It then trades bytes between that engine and an external staging buffer, and it finishes with either a stop condition or an access-ready flag. The bus engine does the bit-level signalling and answers each command with a one-cycle done pulse, plus a not-acknowledge flag when the target refuses the byte.

There are two modes. In count mode the programmed count limits the transfer and the remaining count can be read back at any time. In repeat mode the count is ignored: the block keeps moving bytes while the buffer allows it, and it stops only when the host sets the stop bit. A not-acknowledge from the target cancels any pending stop. A control write with the enable bit clear returns the whole block to its reset state.

Top module: `xseq_top`

## Requirements
- R1: The control word keeps only the bits under mask 0xCF87 of a write. The bits are: 15 enable, 14 byte order, 10 master, 9 transmit, 8 extended address, 2 repeat, 1 stop and 0 start. The word reads back on `ctl_q`.
- R2: A start is accepted only when the written word has enable and master set and extended address clear, and only while the block is idle. An accepted start issues command kind 0 (address) with `cmd_addr` equal to `tgt_addr` and `cmd_rnw` equal to the inverse of the transmit bit. A start that is not accepted leaves the start bit clear. Command kinds are 0 address, 1 write, 2 read and 3 stop. A command stays valid until its done pulse arrives.
- R3: A not-acknowledge on the address phase or on a data byte sets `st_nack` and clears the stop bit. No stop command is issued and the block returns to idle.
- R4: After an acknowledged address phase the start bit clears and `cnt_cur` loads the programmed count. In count mode each data byte lowers `cnt_cur` by one, and exactly that many data commands are issued.
- R5: When the count reaches zero with the stop bit set, one stop command (kind 3) is issued. When it completes, the stop bit clears and `cnt_cur` reloads the programmed count.
- R6: When the count reaches zero with the stop bit clear, `st_ardy` sets and the master bit clears.
- R7: In transmit count mode, `st_xrdy` is set after a byte only while bytes remain to be sent and no not-acknowledge has occurred. It is clear once the count is exhausted.
- R8: In repeat mode `cnt_cur` does not change while bytes move. Transmit drains every pending buffer byte and then sets `st_xrdy`. Receive fills the buffer to DEPTH bytes and sets `st_rrdy`. A set stop bit issues a stop at once.
- R9: A `rx_drained` pulse during a master receive sets `st_ardy` and clears the master bit. The transfer then ends with no further read commands.
- R10: A control write with enable clear resets the control word, the programmed and current counts, and all status flags.
- R11: No data command is issued while `eng_busy` is low, while the transmit buffer is empty (transmit), or while the receive buffer holds DEPTH bytes (receive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| cnt_we | input | 1 | Byte count write strobe |
| cnt_wdata | input | CW | Programmed byte count |
| tgt_addr | input | AW | Target address for the address phase |
| ctl_q | output | 16 | Control word readback |
| cnt_cur | output | CW | Current remaining count |
| cmd_valid | output | 1 | Command to bus engine pending |
| cmd_kind | output | 2 | 0 address, 1 write, 2 read, 3 stop |
| cmd_addr | output | AW | Address for address command |
| cmd_rnw | output | 1 | Direction for address command, 1 = read |
| eng_done | input | 1 | Bus engine finished current command |
| eng_nack | input | 1 | Target refused, qualified by eng_done |
| eng_busy | input | 1 | Bus engine holds the bus |
| tx_level | input | LW | Bytes pending in transmit buffer |
| tx_pop | output | 1 | One transmit byte consumed |
| rx_level | input | LW | Bytes held in receive buffer |
| rx_push | output | 1 | One received byte to store |
| rx_drained | input | 1 | Host took the last receive byte |
| st_nack | output | 1 | Not-acknowledge status |
| st_ardy | output | 1 | Access-ready status |
| st_xrdy | output | 1 | Transmit-ready status |
| st_rrdy | output | 1 | Receive-ready status |

## Verification
A control write is captured on one edge, and the address command appears right after that edge. The engine model answers one edge after it sees a command. The sequencer acts on the done pulse at the following edge, so each data byte takes three cycles. The count, the status flags and the stop-bit clear all change on the same edge that consumes a done pulse. Because of this, every check waits a fixed number of falling edges that covers the longest transfer in that scenario, plus margin, and samples only settled outputs. Stalled scenarios are sampled while the block is held, and again after the holding condition is released.

// File: rtl/xseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the byte-count transfer sequencer.
// Assumes a 16-bit control word; bit positions are fixed by the control layout.
package xseq_pkg;
    localparam int B_EN  = 15;
    localparam int B_ORD = 14;
    localparam int B_MST = 10;
    localparam int B_TRX = 9;
    localparam int B_XA  = 8;
    localparam int B_RPT = 2;
    localparam int B_STP = 1;
    localparam int B_STT = 0;
    localparam logic [15:0] CTL_KEEP = 16'hCF87;

    typedef enum logic [1:0] {
        CMD_ADDR = 2'd0,
        CMD_WR   = 2'd1,
        CMD_RD   = 2'd2,
        CMD_STOP = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_XFER, SQ_STOP
    } sq_e;

    typedef struct packed {
        logic ld_cnt;
        logic dec_cnt;
        logic clr_stt;
        logic clr_stp;
        logic clr_mst;
        logic set_nack;
        logic set_ardy;
        logic xrdy_set;
        logic xrdy_clr;
        logic rrdy_set;
    } act_t;
endpackage

// File: rtl/xseq_ctl.sv
`timescale 1ns/1ps
// Control word storage. A host write replaces the kept bits; the start bit
// is stored only when the start is accepted. Sequencer clears apply when
// no host write occurs in the same cycle (the write wins).
module xseq_ctl
    import xseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        ctl_we,
    input  logic [15:0] ctl_wdata,
    input  logic        start_go,
    input  logic        clr_stt,
    input  logic        clr_stp,
    input  logic        clr_mst,
    output logic [15:0] ctl
);
    logic [15:0] ctl_nxt;

    // Next control word from host write or sequencer self-clears.
    always_comb begin
        ctl_nxt = ctl;
        if (ctl_we) begin
            ctl_nxt        = ctl_wdata & CTL_KEEP;
            ctl_nxt[B_STT] = start_go;
        end else begin
            if (clr_stt) ctl_nxt[B_STT] = 1'b0;
            if (clr_stp) ctl_nxt[B_STP] = 1'b0;
            if (clr_mst) ctl_nxt[B_MST] = 1'b0;
        end
    end

    // Control register with hard and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) ctl <= '0;
        else                    ctl <= ctl_nxt;
    end
endmodule

// File: rtl/xseq_count.sv
`timescale 1ns/1ps
// Programmed and current byte counts. The current count loads from the
// programmed count and steps down by one per counted byte.
// Assumes the sequencer never requests a decrement at zero.
module xseq_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          prog_we,
    input  logic [CW-1:0] prog_val,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] prog,
    output logic [CW-1:0] cur
);
    // Programmed count register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) prog <= '0;
        else if (prog_we)       prog <= prog_val;
    end

    // Current remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) cur <= '0;
        else if (load)          cur <= prog;
        else if (dec)           cur <= cur - CW'(1);
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !soft_rst) |-> (cur != '0)); // R4
endmodule

// File: rtl/xseq_status.sv
`timescale 1ns/1ps
// Status flags: not-acknowledge, access-ready, transmit-ready, receive-ready.
// Sticky flags clear only by reset; receive-ready drops when the buffer empties.
module xseq_status
    import xseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  act_t act,
    input  logic rx_empty,
    output logic st_nack,
    output logic st_ardy,
    output logic st_xrdy,
    output logic st_rrdy
);
    // Sticky error and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st_nack <= 1'b0;
            st_ardy <= 1'b0;
        end else begin
            if (act.set_nack) st_nack <= 1'b1;
            if (act.set_ardy) st_ardy <= 1'b1;
        end
    end

    // Buffer-side ready flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st_xrdy <= 1'b0;
            st_rrdy <= 1'b0;
        end else begin
            if (act.xrdy_set)      st_xrdy <= 1'b1;
            else if (act.xrdy_clr) st_xrdy <= 1'b0;
            if (act.rrdy_set)      st_rrdy <= 1'b1;
            else if (rx_empty)     st_rrdy <= 1'b0;
        end
    end
endmodule

// File: rtl/xseq_fsm.sv
`timescale 1ns/1ps
// Transfer phase machine. It keeps one bus-engine command outstanding and
// walks address, data and stop phases. It emits one-cycle action strobes
// for the control, count and status registers.
// Assumes eng_done is a single-cycle pulse per command.
module xseq_fsm
    import xseq_pkg::*;
#(
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          start_go,
    input  logic [15:0]   ctl,
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] prog,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic          eng_busy,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  logic          rx_drained,
    output logic          idle,
    output logic          cmd_valid,
    output cmd_e          cmd_kind,
    output logic          tx_pop,
    output logic          rx_push,
    output act_t          act
);
    sq_e  st, nxt;
    logic mst, trx, rpt, stp;
    logic tx_avail, rx_room;

    assign mst      = ctl[B_MST];
    assign trx      = ctl[B_TRX];
    assign rpt      = ctl[B_RPT];
    assign stp      = ctl[B_STP];
    assign tx_avail = eng_busy && (tx_level != '0);
    assign rx_room  = eng_busy && (rx_level < LW'(DEPTH));
    assign idle     = (st == SQ_IDLE);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) st <= SQ_IDLE;
        else                    st <= nxt;
    end

    // Command presented to the bus engine in each phase.
    always_comb begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_ADDR;
        unique case (st)
            SQ_ADDR: cmd_kind = CMD_ADDR;
            SQ_XFER: cmd_kind = trx ? CMD_WR : CMD_RD;
            SQ_STOP: cmd_kind = CMD_STOP;
            default: cmd_valid = 1'b0;
        endcase
    end

    // Phase transitions and action strobes.
    always_comb begin
        nxt     = st;
        act     = '0;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (st)
            SQ_IDLE: if (start_go) nxt = SQ_ADDR;
            SQ_ADDR: if (eng_done) begin
                act.clr_stt = 1'b1;
                if (eng_nack) begin
                    act.set_nack = 1'b1;
                    act.clr_stp  = 1'b1;
                    nxt          = SQ_IDLE;
                end else begin
                    act.ld_cnt = 1'b1;
                    nxt        = SQ_DATA;
                    if (trx && !rpt) begin
                        act.xrdy_set = (prog != '0);
                        act.xrdy_clr = (prog == '0);
                    end
                end
            end
            SQ_DATA: begin
                if (!mst) begin
                    nxt = SQ_IDLE;
                end else if (rpt) begin
                    if (stp)                   nxt = SQ_STOP;
                    else if (trx && tx_avail)  nxt = SQ_XFER;
                    else if (trx)              act.xrdy_set = (tx_level == '0);
                    else if (rx_room)          nxt = SQ_XFER;
                end else if (cur == '0) begin
                    if (stp) nxt = SQ_STOP;
                    else begin
                        act.set_ardy = 1'b1;
                        act.clr_mst  = 1'b1;
                        nxt          = SQ_IDLE;
                    end
                end else if (trx ? tx_avail : rx_room) begin
                    nxt = SQ_XFER;
                end
            end
            SQ_XFER: if (eng_done) begin
                act.dec_cnt  = !rpt && (cur != '0);
                tx_pop       = trx;
                rx_push      = !trx && !eng_nack;
                act.rrdy_set = !trx && !eng_nack;
                if (eng_nack) begin
                    act.set_nack = 1'b1;
                    act.clr_stp  = 1'b1;
                    act.xrdy_clr = 1'b1;
                    nxt          = SQ_IDLE;
                end else begin
                    if (trx && !rpt) begin
                        act.xrdy_set = (cur != CW'(1));
                        act.xrdy_clr = (cur == CW'(1));
                    end
                    nxt = SQ_DATA;
                end
            end
            SQ_STOP: if (eng_done) begin
                act.clr_stp = 1'b1;
                act.ld_cnt  = 1'b1;
                nxt         = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
        if (rx_drained && mst && !trx) begin
            act.set_ardy = 1'b1;
            act.clr_mst  = 1'b1;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done && !soft_rst) |=> (cmd_valid && $stable(cmd_kind))); // R2
endmodule

// File: rtl/xseq_top.sv
`timescale 1ns/1ps
// Byte-count transfer sequencer top. It ties the control register, the
// counters, the status flags and the phase machine together. Assumes an
// external bus engine and external staging buffers that report their levels.
module xseq_top
    import xseq_pkg::*;
#(
    parameter int CW     = 16,
    parameter int AW     = 10,
    parameter int DEPTH  = 4,
    parameter bit LEGACY = 1'b1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [15:0]   ctl_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [AW-1:0] tgt_addr,
    output logic [15:0]   ctl_q,
    output logic [CW-1:0] cnt_cur,
    output logic          cmd_valid,
    output logic [1:0]    cmd_kind,
    output logic [AW-1:0] cmd_addr,
    output logic          cmd_rnw,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  logic          eng_busy,
    input  logic [LW-1:0] tx_level,
    output logic          tx_pop,
    input  logic [LW-1:0] rx_level,
    output logic          rx_push,
    input  logic          rx_drained,
    output logic          st_nack,
    output logic          st_ardy,
    output logic          st_xrdy,
    output logic          st_rrdy
);
    logic          soft_rst, start_go, idle;
    logic [CW-1:0] prog;
    cmd_e          kind;
    act_t          act;

    assign soft_rst = LEGACY && ctl_we && !ctl_wdata[B_EN];
    assign start_go = ctl_we && idle && ctl_wdata[B_EN] && ctl_wdata[B_MST]
                      && !ctl_wdata[B_XA] && ctl_wdata[B_STT];
    assign cmd_kind = kind;
    assign cmd_addr = tgt_addr;
    assign cmd_rnw  = !ctl_q[B_TRX];

    xseq_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .start_go(start_go),
        .clr_stt(act.clr_stt), .clr_stp(act.clr_stp), .clr_mst(act.clr_mst),
        .ctl(ctl_q)
    );

    xseq_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .prog_we(cnt_we), .prog_val(cnt_wdata),
        .load(act.ld_cnt), .dec(act.dec_cnt),
        .prog(prog), .cur(cnt_cur)
    );

    xseq_status u_sts (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .act(act),
        .rx_empty(rx_level == '0),
        .st_nack(st_nack), .st_ardy(st_ardy), .st_xrdy(st_xrdy), .st_rrdy(st_rrdy)
    );

    xseq_fsm #(.CW(CW), .DEPTH(DEPTH), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_go(start_go),
        .ctl(ctl_q), .cur(cnt_cur), .prog(prog),
        .tx_level(tx_level), .rx_level(rx_level), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_nack(eng_nack), .rx_drained(rx_drained),
        .idle(idle), .cmd_valid(cmd_valid), .cmd_kind(kind),
        .tx_pop(tx_pop), .rx_push(rx_push), .act(act)
    );

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_WR && !$past(cmd_valid))
        |-> ($past(eng_busy) && $past(tx_level) != '0)); // R11
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_RD && !$past(cmd_valid))
        |-> ($past(eng_busy) && $past(rx_level) < LW'(DEPTH))); // R11
    AST_STOP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_STOP && !$past(cmd_valid) && !$past(ctl_we))
        |-> ctl_q[B_STP]); // R5
    AST_NACK_STP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_nack) && !$past(ctl_we)) |-> !ctl_q[B_STP]); // R3
    AST_ARDY_MST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_ardy) && !$past(ctl_we)) |-> !ctl_q[B_MST]); // R6
endmodule

// File: tb/tb_xseq_top.sv
`timescale 1ns/1ps
module tb_xseq_top;
    localparam int CW = 16, AW = 10, DEPTH = 4, LW = 3;
    localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                            XA = 16'h0100, RPT = 16'h0004, STP = 16'h0002, STT = 16'h0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          ctl_we = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic          cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [AW-1:0] tgt_addr = 10'h15A;
    logic [15:0]   ctl_q;
    logic [CW-1:0] cnt_cur;
    logic          cmd_valid, cmd_rnw, tx_pop, rx_push;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic          eng_done = 1'b0, eng_nack = 1'b0, eng_busy = 1'b1;
    logic [LW-1:0] tx_level = '0, rx_level = '0;
    logic          rx_drained = 1'b0;
    logic          st_nack, st_ardy, st_xrdy, st_rrdy;

    int n_addr = 0, n_wr = 0, n_rd = 0, n_stop = 0, n_cmd = 0, nack_at = -1;
    logic          last_rnw = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic          log_clr = 1'b0, tx_set = 1'b0, rx_set = 1'b0;
    logic [LW-1:0] tx_val = '0, rx_val = '0;
    int checks = 0, fails = 0;

    xseq_top dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .tgt_addr(tgt_addr),
        .ctl_q(ctl_q), .cnt_cur(cnt_cur), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_rnw(cmd_rnw), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_busy(eng_busy), .tx_level(tx_level), .tx_pop(tx_pop), .rx_level(rx_level),
        .rx_push(rx_push), .rx_drained(rx_drained), .st_nack(st_nack), .st_ardy(st_ardy),
        .st_xrdy(st_xrdy), .st_rrdy(st_rrdy)
    );

    // Bus engine and staging buffer model.
    always @(posedge clk) begin
        if (log_clr) begin
            n_addr <= 0; n_wr <= 0; n_rd <= 0; n_stop <= 0; n_cmd <= 0;
            eng_done <= 1'b0; eng_nack <= 1'b0;
        end else if (cmd_valid && !eng_done) begin
            eng_done <= 1'b1;
            eng_nack <= (n_cmd == nack_at);
            n_cmd <= n_cmd + 1;
            case (cmd_kind)
                2'd0: begin n_addr <= n_addr + 1; last_addr <= cmd_addr; last_rnw <= cmd_rnw; end
                2'd1: n_wr <= n_wr + 1;
                2'd2: n_rd <= n_rd + 1;
                default: n_stop <= n_stop + 1;
            endcase
        end else begin
            eng_done <= 1'b0;
            eng_nack <= 1'b0;
        end
        if (tx_set) tx_level <= tx_val;
        else if (tx_pop) tx_level <= tx_level - 1'b1;
        if (rx_set) rx_level <= rx_val;
        else if (rx_push) rx_level <= rx_level + 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_cnt(input int v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = CW'(v);
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic clr_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    // Soft reset, program count, load buffers, clear the engine log.
    task automatic prep(input int cnt, input int tx, input int rx, input int nk);
        wr_ctl(16'h0000);
        wr_cnt(cnt);
        @(negedge clk);
        log_clr = 1'b1; tx_set = 1'b1; tx_val = LW'(tx); rx_set = 1'b1; rx_val = LW'(rx);
        nack_at = nk;
        @(negedge clk);
        log_clr = 1'b0; tx_set = 1'b0; rx_set = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R10 reset state
        chk("R10 reset ctl", int'(ctl_q), 0);
        chk("R10 reset cnt", int'(cnt_cur), 0);
        chk("R10 reset status", int'({st_nack, st_ardy, st_xrdy, st_rrdy}), 0);
        chk("R2 reset no command", int'(cmd_valid), 0);

        // R1 masking, no start without start bit
        prep(0, 0, 0, -1);
        wr_ctl(16'hFFFE);
        wait_cyc(5);
        chk("R1 masked control", int'(ctl_q), 16'hCF86);
        chk("R1 no address", n_addr, 0);

        // R2 blocked starts
        prep(2, 2, 0, -1);
        wr_ctl(EN | MST | XA | STT);
        wait_cyc(10);
        chk("R2 ext addr blocks start", n_addr, 0);
        chk("R2 start bit not kept", int'(ctl_q[0]), 0);
        wr_ctl(EN | STT);
        wait_cyc(10);
        chk("R2 no master blocks start", n_addr, 0);

        // R4 R5 R6 R7 count-mode sweep
        for (int trx = 0; trx < 2; trx++) begin
            for (int stp = 0; stp < 2; stp++) begin
                for (int c = 0; c <= DEPTH; c++) begin
                    prep(c, trx ? c : 0, 0, -1);
                    wr_ctl(EN | MST | (trx ? TRX : 16'h0) | (stp ? STP : 16'h0) | STT);
                    wait_cyc(40);
                    chk("R2 one address", n_addr, 1);
                    chk("R2 address value", int'(last_addr), int'(tgt_addr));
                    chk("R2 direction", int'(last_rnw), trx ? 0 : 1);
                    chk("R2 start self-clear", int'(ctl_q[0]), 0);
                    chk("R4 bytes moved", trx ? n_wr : n_rd, c);
                    chk("R5 stop issued", n_stop, stp);
                    chk("R5 stop bit cleared", int'(ctl_q[1]), 0);
                    chk("R5 R6 count after end", int'(cnt_cur), stp ? c : 0);
                    chk("R6 ardy", int'(st_ardy), stp ? 0 : 1);
                    chk("R6 master bit", int'(ctl_q[10]), stp);
                    chk("R3 no nack", int'(st_nack), 0);
                    if (trx) chk("R7 xrdy clear at end", int'(st_xrdy), 0);
                end
            end
        end

        // R7 R11 transmit stalls on empty buffer
        prep(3, 1, 0, -1);
        wr_ctl(EN | MST | TRX | STP | STT);
        wait_cyc(30);
        chk("R11 tx empty stall bytes", n_wr, 1);
        chk("R4 remaining count", int'(cnt_cur), 2);
        chk("R7 xrdy while bytes remain", int'(st_xrdy), 1);
        chk("R11 no stop while stalled", n_stop, 0);
        @(negedge clk); tx_set = 1'b1; tx_val = 3'd2;
        @(negedge clk); tx_set = 1'b0;
        wait_cyc(30);
        chk("R4 resumed bytes", n_wr, 3);
        chk("R5 stop after resume", n_stop, 1);
        chk("R7 xrdy after last", int'(st_xrdy), 0);
        chk("R5 reload", int'(cnt_cur), 3);

        // R11 engine not busy
        eng_busy = 1'b0;
        prep(2, 2, 0, -1);
        wr_ctl(EN | MST | TRX | STT);
        wait_cyc(20);
        chk("R11 busy low address still", n_addr, 1);
        chk("R11 busy low no writes", n_wr, 0);
        chk("R4 count loaded", int'(cnt_cur), 2);
        eng_busy = 1'b1;
        wait_cyc(20);
        chk("R11 busy high writes", n_wr, 2);
        chk("R6 ardy after busy", int'(st_ardy), 1);

        // R11 receive buffer full
        prep(3, 0, 3, -1);
        wr_ctl(EN | MST | STT);
        wait_cyc(30);
        chk("R11 rx full stall", n_rd, 1);
        chk("R4 rx remaining", int'(cnt_cur), 2);

        // R3 nack on address
        prep(3, 3, 0, 0);
        wr_ctl(EN | MST | TRX | STP | STT);
        wait_cyc(30);
        chk("R3 addr nack no writes", n_wr, 0);
        chk("R3 addr nack no stop", n_stop, 0);
        chk("R3 addr nack flag", int'(st_nack), 1);
        chk("R3 addr nack stop bit", int'(ctl_q[1]), 0);

        // R3 nack on second data byte
        prep(3, 3, 0, 2);
        wr_ctl(EN | MST | TRX | STP | STT);
        wait_cyc(40);
        chk("R3 data nack writes", n_wr, 2);
        chk("R3 data nack no stop", n_stop, 0);
        chk("R3 data nack flag", int'(st_nack), 1);
        chk("R3 data nack stop bit", int'(ctl_q[1]), 0);
        chk("R4 count at nack", int'(cnt_cur), 1);
        chk("R7 xrdy after nack", int'(st_xrdy), 0);

        // R10 legacy reset through control write
        wr_ctl(16'h4606);
        wait_cyc(2);
        chk("R10 ctl cleared", int'(ctl_q), 0);
        chk("R10 nack cleared", int'(st_nack), 0);
        chk("R10 count cleared", int'(cnt_cur), 0);
        clr_log();
        wr_ctl(EN | MST | TRX | STP | STT);
        wait_cyc(20);
        chk("R10 programmed count cleared", n_wr, 0);
        chk("R10 stop at zero count", n_stop, 1);

        // R8 R9 repeat receive
        prep(2, 0, 0, -1);
        wr_ctl(EN | MST | RPT | STT);
        wait_cyc(40);
        chk("R8 rx fills buffer", n_rd, DEPTH);
        chk("R8 rrdy", int'(st_rrdy), 1);
        chk("R8 count untouched", int'(cnt_cur), 2);
        @(negedge clk); rx_set = 1'b1; rx_val = '0; rx_drained = 1'b1;
        @(negedge clk); rx_set = 1'b0; rx_drained = 1'b0;
        wait_cyc(20);
        chk("R9 ardy on drain", int'(st_ardy), 1);
        chk("R9 master cleared", int'(ctl_q[10]), 0);
        chk("R9 no more reads", n_rd, DEPTH);

        // R8 repeat transmit then stop
        prep(5, 3, 0, -1);
        wr_ctl(EN | MST | TRX | RPT | STT);
        wait_cyc(30);
        chk("R8 tx drains", n_wr, 3);
        chk("R8 xrdy when drained", int'(st_xrdy), 1);
        chk("R8 tx count untouched", int'(cnt_cur), 5);
        chk("R8 no stop yet", n_stop, 0);
        wr_ctl(EN | MST | TRX | RPT | STP);
        wait_cyc(10);
        chk("R8 stop issued", n_stop, 1);
        chk("R5 repeat stop bit cleared", int'(ctl_q[1]), 0);
        chk("R8 no ardy on stop", int'(st_ardy), 0);
        chk("R8 no extra writes", n_wr, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule